// File: doc/BRIEF.md
# Dual-Mode Host Parallel Bus Port

This block connects an 8-bit host microprocessor to four independent channel register files. The host may use either of two strobe styles. In the first style it issues separate active-low read and write strobes. In the second style it issues one active-low data strobe together with a read/write level. Each style works with either of two address schemes. In the multiplexed scheme the address travels on the data pins and is latched by an address strobe. In the separate scheme a dedicated 5-bit address bus carries it. Two strap inputs select the style and the scheme, and they may change between accesses.

All host-side control pins are asynchronous to the block's clock. They pass through two-flop synchronizers, and every register update happens on the internal clock. Each channel has its own active-low chip select. Each channel holds 32 eight-bit locations. Locations 0 to 29 are general control storage. Location 30 is an interrupt mask. Location 31 holds latched status flags, which are set from per-channel condition inputs and cleared by writing ones. The block drives an open-drain, active-low interrupt line by means of a pull-down enable. The enable is on whenever any channel has a latched status bit whose mask bit is also set. A synchronous active-low reset clears every register.

The data pins are split at the pad boundary into an input bus, an output bus and an output enable. The host must hold the address and data pins steady for at least four clock cycles after each strobe edge it makes, so that the synchronized strobes still see valid values.

Top module: `hostbus_port`

## Requirements
- R1: While `rst_n` is low at a clock edge, every location of every channel (control, mask and status) is cleared to 0. After reset, `d_oe` and `irq_drive_low` are 0 until an access or an enabled status bit drives them.
- R2: With `bus_motorola`=0, a low pulse on `wr_rw_n` writes `d_in` to the addressed location, and a low level on `rd_ds_n` reads that location back on `d_out`.
- R3: With `bus_motorola`=1, `rd_ds_n` is the active-low data strobe and `wr_rw_n` is a level that selects the direction: 1 means read, 0 means write.
- R4: With `bus_muxed`=1, the address is taken from `d_in[4:0]` on the rising edge of `ale_as`, and the `addr` pins are ignored. With `bus_muxed`=0, the address comes from `addr`.
- R5: `cs_n[k]` low allows access to channel k only (bit k of `cs_n` corresponds to channel k). An access made while every bit of `cs_n` is high reads nothing and changes nothing.
- R6: `d_oe` is 1 only while a read access is active with at least one chip select low. It is never 1 during a write or while the bus is idle.
- R7: Each write strobe commits exactly once, on its trailing edge (after synchronization). The committed value is the data seen in the last cycle in which the strobe was active.
- R8: Location 31 returns the channel's latched status. Status bit i becomes 1 while `cond_in` bit i of that channel is 1, and also in the cycle after that input falls. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: Location 30 holds the interrupt mask. `irq_drive_low` is 1 exactly when, for some channel, the latched status ANDed with the mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| bus_motorola | input | 1 | Strobe style: 1 = data strobe plus direction level, 0 = separate read and write strobes |
| bus_muxed | input | 1 | Address scheme: 1 = address on the data pins, 0 = dedicated address bus |
| rd_ds_n | input | 1 | Read strobe or data strobe, active low |
| wr_rw_n | input | 1 | Write strobe, or direction level (1 = read) |
| ale_as | input | 1 | Address latch; its rising edge captures the address in multiplexed mode |
| cs_n | input | 4 | Per-channel chip selects, active low |
| addr | input | 5 | Dedicated address bus |
| d_in | input | 8 | Data (and multiplexed address) from the pads |
| d_out | output | 8 | Read data to the pads |
| d_oe | output | 1 | Pad output enable for `d_out` |
| cond_in | input | 32 | Status conditions, 8 per channel; channel k uses bits 8k+7..8k |
| irq_drive_low | output | 1 | Pull-down enable of the open-drain, active-low interrupt pad |

## Verification
The bench builds the block with its default parameters: four channels, 5-bit addressing and 8-bit data. This lets it cover both strobe styles crossed with both address schemes, chip-select isolation across four distinct channels, and the two special locations at the top of the 32-entry map. Because the address width is 5, the mask and status locations sit at 30 and 31. This puts the boundary between control storage and the special locations within reach of ordinary accesses. The bench checks that the `addr` pins have no effect in multiplexed mode, that a write strobe with no chip select low has no effect, and that data changed in the middle of a strobe is the value committed.

// File: rtl/hostbus_pkg.sv
// Package: shared types and map helpers for the host bus port.
// Assumes the special locations sit at the top of each channel map.
package hostbus_pkg;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;

    // Index of the status location for a given address width.
    function automatic int unsigned stat_index(input int unsigned aw);
        return (32'd1 << aw) - 32'd1;
    endfunction

    // Index of the interrupt mask location for a given address width.
    function automatic int unsigned mask_index(input int unsigned aw);
        return (32'd1 << aw) - 32'd2;
    endfunction

endpackage

// File: rtl/hostbus_sync.sv
// Two-flop synchronizer for a bundle of asynchronous host pins.
// Assumes each bit is independent; the reset value is a parameter, so
// active-low strobes can rest inactive (high) during reset.
module hostbus_sync #(
    parameter int unsigned W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/hostbus_decode.sv
// Strobe decoder: turns the synchronized host pins into a one-cycle
// write pulse with captured address, data and channel set, and into a
// live read enable and read address.
// Assumes the host holds address and data for 4 or more clocks after each strobe edge.
module hostbus_decode
    import hostbus_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 5,
    parameter int unsigned DW  = 8,
    localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           motorola,
    input  logic           muxed,
    input  logic           rd_s_n,
    input  logic           wr_s_n,
    input  logic           ale_s,
    input  logic [NCH-1:0] cs_s_n,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  d_in,
    output logic           wr_pulse,
    output logic [NCH-1:0] wr_sel,
    output logic [AW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data,
    output logic           rd_en,
    output logic [IW-1:0]  rd_idx,
    output logic [AW-1:0]  rd_addr
);
    logic          strobe_act;
    acc_kind_e     cur_kind;
    logic          act_q;
    acc_kind_e     kind_q;
    logic [NCH-1:0] sel_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] ale_addr_q;
    logic [AW-1:0] waddr_q;
    logic [DW-1:0] wdata_q;
    logic          ale_q;
    logic [AW-1:0] cur_addr;

    // Interpret the strobe pins according to the bus style strap.
    always_comb begin
        if (motorola) begin
            strobe_act = !rd_s_n;
            cur_kind   = wr_s_n ? ACC_READ : ACC_WRITE;
        end else begin
            strobe_act = !rd_s_n || !wr_s_n;
            cur_kind   = !wr_s_n ? ACC_WRITE : ACC_READ;
        end
    end

    assign cur_addr = muxed ? ale_addr_q : addr_q;

    // Register the address bus and latch the multiplexed address on ALE rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            ale_addr_q <= '0;
            ale_q      <= 1'b0;
        end else begin
            addr_q <= addr;
            ale_q  <= ale_s;
            if (muxed && ale_s && !ale_q) begin
                ale_addr_q <= d_in[AW-1:0];
            end
        end
    end

    // Track the strobe and capture the access while it is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            kind_q  <= ACC_READ;
            sel_q   <= '0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            act_q <= strobe_act;
            if (strobe_act) begin
                kind_q  <= cur_kind;
                sel_q   <= ~cs_s_n;
                waddr_q <= cur_addr;
                wdata_q <= d_in;
            end
        end
    end

    assign wr_pulse = act_q && !strobe_act && (kind_q == ACC_WRITE) && (|sel_q);
    assign wr_sel   = sel_q;
    assign wr_addr  = waddr_q;
    assign wr_data  = wdata_q;
    assign rd_en    = strobe_act && (cur_kind == ACC_READ) && (cs_s_n != '1);
    assign rd_addr  = cur_addr;

    // Pick the lowest-numbered selected channel as the read source.
    always_comb begin
        rd_idx = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (!cs_s_n[k]) begin
                rd_idx = IW'(k);
            end
        end
    end
endmodule

// File: rtl/hostbus_chanregs.sv
// One channel's register file: general control locations, an
// interrupt mask and write-one-to-clear latched status flags.
// Assumes cond is already in the clock domain.
module hostbus_chanregs
    import hostbus_pkg::*;
#(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 8,
    localparam int unsigned NGEN = mask_index(AW),
    localparam logic [AW-1:0] STAT_A = AW'(stat_index(AW)),
    localparam logic [AW-1:0] MASK_A = AW'(mask_index(AW))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] cond,
    output logic [DW-1:0] rd_data,
    output logic          irq,
    output logic          mask_any
);
    logic [DW-1:0] gen_q [NGEN];
    logic [DW-1:0] mask_q;
    logic [DW-1:0] stat_q;
    logic [DW-1:0] cond_q;
    logic [DW-1:0] set_evt;
    logic [DW-1:0] clr_bits;

    assign set_evt  = cond | (cond_q & ~cond);
    assign clr_bits = (wr_en && wr_addr == STAT_A) ? wr_data : '0;

    // General control locations and the mask, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NGEN); i++) gen_q[i] <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == MASK_A) begin
                mask_q <= wr_data;
            end else if (wr_addr != STAT_A) begin
                gen_q[wr_addr] <= wr_data;
            end
        end
    end

    // Status latch: set on condition level or fall, clear on write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            cond_q <= '0;
        end else begin
            cond_q <= cond;
            stat_q <= (stat_q & ~clr_bits) | set_evt;
        end
    end

    // Read multiplexer over the channel's map.
    always_comb begin
        if (rd_addr == STAT_A)      rd_data = stat_q;
        else if (rd_addr == MASK_A) rd_data = mask_q;
        else                        rd_data = gen_q[rd_addr];
    end

    assign irq      = |(stat_q & mask_q);
    assign mask_any = |mask_q;
endmodule

// File: rtl/hostbus_port.sv
// Top of the host parallel bus port: synchronizes the host pins,
// decodes accesses and routes them to one register file per channel.
// Assumes the straps are steady during an access; data pins are split
// into input, output and enable at the pad boundary.
module hostbus_port #(
    parameter int unsigned NCH = 4,
    parameter int unsigned AW  = 5,
    parameter int unsigned DW  = 8,
    localparam int unsigned IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_motorola,
    input  logic             bus_muxed,
    input  logic             rd_ds_n,
    input  logic             wr_rw_n,
    input  logic             ale_as,
    input  logic [NCH-1:0]   cs_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    d_in,
    output logic [DW-1:0]    d_out,
    output logic             d_oe,
    input  logic [NCH*DW-1:0] cond_in,
    output logic             irq_drive_low
);
    localparam int unsigned SW = NCH + 3;

    logic [SW-1:0]  pins_raw;
    logic [SW-1:0]  pins_s;
    logic           wr_pulse;
    logic [NCH-1:0] wr_sel;
    logic [AW-1:0]  wr_addr;
    logic [DW-1:0]  wr_data;
    logic           rd_en;
    logic [IW-1:0]  rd_idx;
    logic [AW-1:0]  rd_addr;
    logic [DW-1:0]  chan_rd [NCH];
    logic [NCH-1:0] chan_irq;
    logic [NCH-1:0] mask_any;

    assign pins_raw = {ale_as, wr_rw_n, rd_ds_n, cs_n};

    hostbus_sync #(
        .W(SW),
        .RST_VAL({1'b0, {(SW - 1){1'b1}}})
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_raw),
        .q     (pins_s)
    );

    hostbus_decode #(.NCH(NCH), .AW(AW), .DW(DW)) i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .motorola (bus_motorola),
        .muxed    (bus_muxed),
        .rd_s_n   (pins_s[NCH]),
        .wr_s_n   (pins_s[NCH+1]),
        .ale_s    (pins_s[NCH+2]),
        .cs_s_n   (pins_s[NCH-1:0]),
        .addr     (addr),
        .d_in     (d_in),
        .wr_pulse (wr_pulse),
        .wr_sel   (wr_sel),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .rd_addr  (rd_addr)
    );

    for (genvar k = 0; k < int'(NCH); k++) begin : g_chan
        hostbus_chanregs #(.AW(AW), .DW(DW)) i_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_pulse && wr_sel[k]),
            .wr_addr  (wr_addr),
            .wr_data  (wr_data),
            .rd_addr  (rd_addr),
            .cond     (cond_in[k*DW +: DW]),
            .rd_data  (chan_rd[k]),
            .irq      (chan_irq[k]),
            .mask_any (mask_any[k])
        );
    end

    assign d_oe          = rd_en;
    assign d_out         = rd_en ? chan_rd[rd_idx] : '0;
    assign irq_drive_low = |chan_irq;
endmodule

// File: rtl/hostbus_port_chk.sv
// Checker for the host bus port, attached by bind. Looks at ports and
// at the decode-to-register-file boundary signals.
module hostbus_port_chk #(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] cs_n,
    input logic           d_oe,
    input logic           irq_drive_low,
    input logic           wr_pulse,
    input logic [NCH-1:0] mask_any
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_drive_low && !d_oe)); // R1

    AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> ($past(cs_n, 3) != '1)); // R5

    AST_DRIVE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> ($past(cs_n, 2) != '1)); // R6

    AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse); // R7

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_drive_low |-> (mask_any != '0)); // R9
endmodule

bind hostbus_port hostbus_port_chk #(.NCH(NCH)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .d_oe          (d_oe),
    .irq_drive_low (irq_drive_low),
    .wr_pulse      (wr_pulse),
    .mask_any      (mask_any)
);

// File: tb/test_hostbus_port.sv
// Scoreboard bench: access tasks push expected read data into a queue;
// a monitor pops and compares when the port drives the bus.
module test_hostbus_port;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_motorola = 1'b0;
    logic        bus_muxed = 1'b0;
    logic        rd_ds_n = 1'b1;
    logic        wr_rw_n = 1'b1;
    logic        ale_as = 1'b0;
    logic [3:0]  cs_n = 4'hF;
    logic [4:0]  addr = '0;
    logic [7:0]  d_in = '0;
    logic [7:0]  d_out;
    logic        d_oe;
    logic [31:0] cond_in = '0;
    logic        irq_drive_low;

    int n_checks = 0;
    int n_fail = 0;
    bit rd_window = 1'b0;
    int oe_cnt = 0;
    logic [7:0] exp_val [$];
    string      exp_tag [$];
    logic [7:0] model [NCH][32];

    always #5 clk = ~clk;

    hostbus_port i_hostbus_port (
        .clk(clk), .rst_n(rst_n), .bus_motorola(bus_motorola), .bus_muxed(bus_muxed),
        .rd_ds_n(rd_ds_n), .wr_rw_n(wr_rw_n), .ale_as(ale_as), .cs_n(cs_n),
        .addr(addr), .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
        .cond_in(cond_in), .irq_drive_low(irq_drive_low)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [3:0] csv(input int ch);
        return (ch < NCH) ? ~(4'b1 << ch) : 4'hF;
    endfunction

    // Set up the address phase for either scheme.
    task automatic addr_phase(input bit mux, input int a);
        if (mux) begin
            addr = 5'd7;
            d_in = 8'(a);
            ale_as = 1'b1;
            step(5);
            ale_as = 1'b0;
            step(2);
        end else begin
            addr = 5'(a);
        end
    endtask

    // Host write; data changes from v0 to v1 in the middle of the strobe.
    task automatic do_write(input bit moto, input bit mux, input int ch, input int a,
                            input logic [7:0] v0, input logic [7:0] v1);
        bus_motorola = moto;
        bus_muxed = mux;
        step(1);
        addr_phase(mux, a);
        d_in = v0;
        cs_n = csv(ch);
        if (moto) wr_rw_n = 1'b0;
        step(2);
        if (moto) rd_ds_n = 1'b0; else wr_rw_n = 1'b0;
        step(4);
        d_in = v1;
        step(5);
        if (moto) rd_ds_n = 1'b1; else wr_rw_n = 1'b1;
        step(5);
        cs_n = 4'hF;
        wr_rw_n = 1'b1;
        step(3);
        if (ch < NCH && a != 31) model[ch][a] = v1;
    endtask

    // Host read; pushes the expected value unless no channel is selected.
    task automatic do_read(input bit moto, input bit mux, input int ch, input int a,
                           input logic [7:0] expv, input string tag);
        bus_motorola = moto;
        bus_muxed = mux;
        step(1);
        addr_phase(mux, a);
        cs_n = csv(ch);
        wr_rw_n = 1'b1;
        step(2);
        if (ch < NCH) begin
            exp_val.push_back(expv);
            exp_tag.push_back(tag);
            rd_window = 1'b1;
        end
        rd_ds_n = 1'b0;
        step(7);
        rd_ds_n = 1'b1;
        step(4);
        rd_window = 1'b0;
        cs_n = 4'hF;
        step(3);
    endtask

    task automatic final_report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Monitor: compare read data on the second driven cycle; flag stray drive.
    initial begin
        bit stray;
        stray = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                oe_cnt = 0;
            end else begin
                if (d_oe && !rd_window) stray = 1'b1;
                oe_cnt = d_oe ? oe_cnt + 1 : 0;
                if (oe_cnt == 2) begin
                    if (exp_val.size() == 0) begin
                        check("R6 unexpected read drive", d_out, 8'hxx);
                    end else begin
                        check(exp_tag.pop_front(), d_out, exp_val.pop_front());
                    end
                end
                if (stray) begin
                    check("R6 bus driven outside a selected read", 8'd1, 8'd0);
                    stray = 1'b0;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        final_report();
    end

    initial begin
        for (int c = 0; c < NCH; c++) for (int a = 0; a < 32; a++) model[c][a] = '0;
        step(4);
        rst_n = 1'b1;
        step(3);
        // R1: reset state at the ports and in the map
        check("R1 d_oe after reset", {7'd0, d_oe}, 8'd0);
        check("R1 irq after reset", {7'd0, irq_drive_low}, 8'd0);
        do_read(1'b0, 1'b0, 0, 5, 8'h00, "R1 control location cleared");
        do_read(1'b0, 1'b0, 3, 31, 8'h00, "R1 status cleared");

        // R2: separate-strobe style, dedicated address bus
        do_write(1'b0, 1'b0, 0, 3, 8'hA5, 8'hA5);
        do_read(1'b0, 1'b0, 0, 3, 8'hA5, "R2 separate strobes ch0 a3");
        do_write(1'b0, 1'b0, 2, 17, 8'h3C, 8'h3C);
        do_read(1'b0, 1'b0, 2, 17, 8'h3C, "R2 separate strobes ch2 a17");

        // R3: data strobe with direction level
        do_write(1'b1, 1'b0, 1, 29, 8'h5A, 8'h5A);
        do_read(1'b1, 1'b0, 1, 29, 8'h5A, "R3 data strobe ch1 a29");
        do_read(1'b1, 1'b0, 0, 3, 8'hA5, "R3 data strobe reads earlier write");

        // R4: multiplexed address, addr pins held at 7 and ignored
        do_write(1'b0, 1'b1, 3, 10, 8'h77, 8'h77);
        do_read(1'b0, 1'b0, 3, 10, 8'h77, "R4 muxed write lands at latched address");
        do_read(1'b0, 1'b0, 3, 7, 8'h00, "R4 addr pins ignored in muxed mode");
        do_write(1'b1, 1'b1, 2, 4, 8'h99, 8'h99);
        do_read(1'b1, 1'b1, 2, 4, 8'h99, "R4 muxed data strobe round trip");

        // R5: channel isolation and unselected access
        do_read(1'b0, 1'b0, 1, 3, 8'h00, "R5 ch1 untouched by ch0 write");
        do_write(1'b0, 1'b0, NCH, 3, 8'hFF, 8'hFF);
        do_read(1'b0, 1'b0, NCH, 3, 8'h00, "R5 unselected read");
        do_read(1'b0, 1'b0, 0, 3, 8'hA5, "R5 unselected write changed nothing");

        // R7: data changed mid-strobe, last value commits
        do_write(1'b0, 1'b0, 0, 12, 8'h11, 8'hE2);
        do_read(1'b0, 1'b0, 0, 12, 8'hE2, "R7 last strobe data committed");

        // R8 / R9: status and interrupt
        cond_in[8 + 2] = 1'b1;
        step(3);
        cond_in[8 + 2] = 1'b0;
        step(3);
        do_read(1'b0, 1'b0, 1, 31, 8'h04, "R8 status latched from condition");
        check("R9 no irq with mask clear", {7'd0, irq_drive_low}, 8'd0);
        do_write(1'b0, 1'b0, 1, 31, 8'h00, 8'h00);
        do_read(1'b0, 1'b0, 1, 31, 8'h04, "R8 write zero keeps status");
        do_write(1'b0, 1'b0, 2, 30, 8'hFF, 8'hFF);
        check("R9 mask without status gives no irq", {7'd0, irq_drive_low}, 8'd0);
        do_write(1'b0, 1'b0, 1, 30, 8'h04, 8'h04);
        check("R9 irq with status and mask", {7'd0, irq_drive_low}, 8'd1);
        do_read(1'b0, 1'b0, 1, 30, 8'h04, "R9 mask readback");
        do_write(1'b0, 1'b0, 1, 31, 8'h04, 8'h04);
        do_read(1'b0, 1'b0, 1, 31, 8'h00, "R8 write one clears status");
        check("R9 irq released after clear", {7'd0, irq_drive_low}, 8'd0);

        // R1: reset clears written values
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(3);
        do_read(1'b0, 1'b0, 0, 3, 8'h00, "R1 reset clears control");
        do_read(1'b0, 1'b0, 2, 30, 8'h00, "R1 reset clears mask");

        step(5);
        check("R6 scoreboard drained", 8'(exp_val.size()), 8'd0);
        final_report();
    end
endmodule